// File: doc/BRIEF.md
# Network Utilization Bar-Graph Meter

This block watches a five-port half-duplex repeater and turns its activity into an eight-LED display. It has two inputs that are sampled on every local clock. The first says that data is being repeated on that clock. The second says that a collision is in progress. Over a fixed measurement window, the block counts the clocks on which each of these inputs is set. When the window ends, it converts each count into an eight-step thermometer bar:

- The utilization bar uses a non-linear ladder from 1% up to 80% or more.
- The collision-rate bar uses a tighter ladder from 1% up to 20% or more.

With the default parameters, the window is 25,000,000 clocks, which is one second at 25 MHz. Each active data clock carries four bits, so a window with every clock active reads as 100%.

A 3-bit select input chooses what the eight LEDs show:

- Code 100 shows the utilization bar.
- Code 101 shows the collision-rate bar.
- Codes 001, 010 and 011 show per-port status: link with receive blink, isolation, and partition. Each port's status bit goes to a fixed LED position.

The block also drives an active-low collision lamp. After a collision the lamp is held on for a fixed time, then forced off for a shorter time. Collisions that arrive during either of those two phases do not extend or restart the lamp.

Top module: `net_util_meter`

## Requirements
- R1: The measurement window is WINDOW clocks long and starts at the first clock edge after reset is released. Both bars are recomputed only at the last clock of each window, counting that clock's inputs, and they hold their values between window ends.
- R2: Bit k of the utilization bar is 1 when the number of data-active clocks in the window is at least WINDOW·p/100, rounded up. Here p is taken from the list 1, 3, 5, 10, 20, 40, 60, 80 for bit 0 up to bit 7.
- R3: Bit k of the collision-rate bar is 1 when the number of collision-active clocks in the window is at least WINDOW·p/100, rounded up. Here p is taken from the list 1, 3, 5, 8, 10, 13, 15, 20 for bit 0 up to bit 7.
- R4: With select 100, `led` equals the utilization bar. With select 101, `led` equals the collision-rate bar. An LED is lit when its bit is 1.
- R5: With select 001, each port's LED is lit when that port's link is good and its receive input is low. The LED positions are: port 0 on LED6, port 1 on LED7, port 2 on LED1, port 3 on LED2, port 4 on LED4.
- R6: With select 010, each port's isolation bit is shown on its LED. With select 011, each port's partition bit is shown on its LED. Both use the same port-to-LED positions as R5.
- R7: In the three status modes (001, 010, 011), LED0, LED3 and LED5 are always off.
- R8: Select codes 000, 110 and 111 turn all eight LEDs off, whatever the bar contents.
- R9: When a collision is sampled while the collision lamp is idle, `col_led_n` goes low from the next clock and stays low for COL_ON clocks.
- R10: After the on phase, `col_led_n` is held high for COL_OFF clocks. Collisions sampled during the on phase or the off phase are ignored. Once the lamp is idle again, a new collision starts a new on phase.
- R11: While reset is asserted, both bars are zero, the window counters are cleared and `col_led_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_act | input | 1 | Data is being repeated on this clock |
| coll_act | input | 1 | A collision is active on this clock |
| disp_sel | input | 3 | Display select code |
| link_ok | input | 5 | Per-port link good |
| rx_act | input | 5 | Per-port receive activity |
| iso_st | input | 5 | Per-port isolated |
| part_st | input | 5 | Per-port partitioned |
| led | output | 8 | LED drive, 1 = lit |
| col_led_n | output | 1 | Collision lamp, active low |

## Verification
The in-line assertions check several properties on every cycle:

- Each bar is always a thermometer code.
- The bars never change except at a window end.
- The unmapped LED positions stay dark in the status modes, and every LED stays dark under the unused select codes.
- An idle lamp lights on the clock after a collision.
- The off phase is never cut short into an on phase.

The exact ladder thresholds cannot be proven by a cycle-local property. This covers the counts just below and exactly at each step, the inclusion of the window's last clock, the port-to-LED positions, and the exact lengths of the lamp's on and off phases. Only the bench's scenarios show these. It drives windows with chosen counts of active clocks and counts clocks across a collision burst.

// File: rtl/net_util_meter.sv
module net_util_meter #(
  parameter int unsigned WINDOW  = 25_000_000,
  parameter int unsigned COL_ON  = 2_000_000,
  parameter int unsigned COL_OFF = 500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_act,
  input  logic       coll_act,
  input  logic [2:0] disp_sel,
  input  logic [4:0] link_ok,
  input  logic [4:0] rx_act,
  input  logic [4:0] iso_st,
  input  logic [4:0] part_st,
  output logic [7:0] led,
  output logic       col_led_n
);

  localparam int CW   = $clog2(WINDOW + 1);
  localparam int TMAX = (COL_ON > COL_OFF) ? COL_ON : COL_OFF;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int UPCT [8] = '{1, 3, 5, 10, 20, 40, 60, 80};
  localparam int CPCT [8] = '{1, 3, 5, 8, 10, 13, 15, 20};
  localparam int PLED [5] = '{6, 7, 1, 2, 4};

  typedef enum logic [1:0] {C_IDLE, C_ON, C_OFF} cst_t;

  logic [CW-1:0] win_cnt, data_cnt, coll_cnt, data_tot, coll_tot;
  logic [7:0]    util_hit, coll_hit, util_bar, col_bar, spread;
  logic [4:0]    port_v;
  logic          win_end;
  cst_t          cst;
  logic [TW-1:0] tcnt;

  assign win_end  = (win_cnt == CW'(WINDOW - 1));
  assign data_tot = data_cnt + CW'(data_act);
  assign coll_tot = coll_cnt + CW'(coll_act);

  for (genvar g = 0; g < 8; g++) begin : g_ladder
    localparam longint unsigned UTHR = (longint'(WINDOW) * UPCT[g] + 99) / 100;
    localparam longint unsigned CTHR = (longint'(WINDOW) * CPCT[g] + 99) / 100;
    assign util_hit[g] = 64'(data_tot) >= UTHR;
    assign coll_hit[g] = 64'(coll_tot) >= CTHR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      data_cnt <= '0;
      coll_cnt <= '0;
      util_bar <= '0;
      col_bar  <= '0;
    end else if (win_end) begin
      win_cnt  <= '0;
      data_cnt <= '0;
      coll_cnt <= '0;
      util_bar <= util_hit;
      col_bar  <= coll_hit;
    end else begin
      win_cnt  <= win_cnt + CW'(1);
      data_cnt <= data_tot;
      coll_cnt <= coll_tot;
    end
  end

  always_comb begin
    case (disp_sel)
      3'b001:  port_v = link_ok & ~rx_act;
      3'b010:  port_v = iso_st;
      3'b011:  port_v = part_st;
      default: port_v = '0;
    endcase
    spread = '0;
    for (int p = 0; p < 5; p++) spread[PLED[p]] = port_v[p];
  end

  always_comb begin
    case (disp_sel)
      3'b001, 3'b010, 3'b011: led = spread;
      3'b100:                 led = util_bar;
      3'b101:                 led = col_bar;
      default:                led = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst  <= C_IDLE;
      tcnt <= '0;
    end else begin
      case (cst)
        C_IDLE: if (coll_act) begin
          cst  <= C_ON;
          tcnt <= '0;
        end
        C_ON: if (tcnt == TW'(COL_ON - 1)) begin
          cst  <= C_OFF;
          tcnt <= '0;
        end else tcnt <= tcnt + TW'(1);
        C_OFF: if (tcnt == TW'(COL_OFF - 1)) begin
          cst  <= C_IDLE;
          tcnt <= '0;
        end else tcnt <= tcnt + TW'(1);
        default: cst <= C_IDLE;
      endcase
    end
  end

  assign col_led_n = (cst != C_ON);

  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(util_bar) && $stable(col_bar))); // R1
  AST_UTIL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((util_bar & (util_bar + 8'd1)) == 8'd0)); // R2
  AST_COLL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((col_bar & (col_bar + 8'd1)) == 8'd0)); // R3
  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_sel inside {3'b001, 3'b010, 3'b011}) |-> ((led & 8'h29) == 8'h00)); // R7
  AST_UNUSED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_sel inside {3'b000, 3'b110, 3'b111}) |-> (led == 8'h00)); // R8
  AST_LAMP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cst == C_IDLE && coll_act) |=> !col_led_n); // R9
  AST_LAMP_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (cst == C_OFF) |=> col_led_n); // R10

endmodule

// File: tb/tb_net_util_meter.sv
`timescale 1ns/10ps
module tb_net_util_meter;
  localparam int W = 100;
  localparam int NV = 11;
  localparam int VEC [NV][4] = '{
    '{0,   0,   8'h00, 8'h00},
    '{1,   1,   8'h01, 8'h01},
    '{2,   2,   8'h01, 8'h01},
    '{3,   3,   8'h03, 8'h03},
    '{9,   7,   8'h07, 8'h07},
    '{10,  8,   8'h0F, 8'h0F},
    '{39,  12,  8'h1F, 8'h1F},
    '{60,  13,  8'h7F, 8'h3F},
    '{79,  19,  8'h7F, 8'h7F},
    '{80,  20,  8'hFF, 8'hFF},
    '{100, 100, 8'hFF, 8'hFF}
  };

  logic clk = 0, rst_n = 0, data_act = 0, coll_act = 0;
  logic [2:0] disp_sel = 3'b100;
  logic [4:0] link_ok = 0, rx_act = 0, iso_st = 0, part_st = 0;
  logic [7:0] led;
  logic col_led_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  net_util_meter #(.WINDOW(W), .COL_ON(20), .COL_OFF(8)) dut (
    .clk(clk), .rst_n(rst_n), .data_act(data_act), .coll_act(coll_act),
    .disp_sel(disp_sel), .link_ok(link_ok), .rx_act(rx_act), .iso_st(iso_st),
    .part_st(part_st), .led(led), .col_led_n(col_led_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic show(input logic [2:0] sel, input string tag, input logic [7:0] exp);
    disp_sel = sel;
    #0.05;
    chk(tag, led, exp);
  endtask

  task automatic run_window(input int nd, input int nc);
    for (int i = 0; i < W; i++) begin
      data_act = (i < nd);
      coll_act = (i < nc);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    show(3'b100, "R11 util bar in reset", 8'h00);
    show(3'b101, "R11 coll bar in reset", 8'h00);
    chk("R11 lamp off in reset", {7'b0, col_led_n}, 8'h01);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      run_window(VEC[v][0], VEC[v][1]);
      show(3'b100, "R2 R4 utilization ladder", 8'(VEC[v][2]));
      show(3'b101, "R3 R4 collision ladder", 8'(VEC[v][3]));
    end

    link_ok = 5'b10110; rx_act = 5'b00100;
    show(3'b001, "R5 link/receive map", 8'h90);
    link_ok = 5'b11111; rx_act = 5'b00000;
    show(3'b001, "R5 R7 all links", 8'hD6);
    iso_st = 5'b01001;
    show(3'b010, "R6 isolation map", 8'h44);
    part_st = 5'b10101;
    show(3'b011, "R6 partition map", 8'h52);
    iso_st = 5'b11111;
    show(3'b010, "R7 isolation all set", 8'hD6);
    show(3'b000, "R8 code 000 dark", 8'h00);
    show(3'b110, "R8 code 110 dark", 8'h00);
    show(3'b111, "R8 code 111 dark", 8'h00);

    data_act = 0; coll_act = 0;
    for (int i = 0; i < W / 2; i++) @(negedge clk);
    show(3'b100, "R1 bar held mid-window", 8'hFF);
    for (int i = 0; i < W / 2; i++) @(negedge clk);
    show(3'b100, "R1 R2 empty window clears bar", 8'h00);

    for (int k = 0; k < 36; k++) begin
      coll_act = (k < 28);
      @(negedge clk);
      if (k == 0)  chk("R9 lamp lit after collision", {7'b0, col_led_n}, 8'h00);
      if (k == 19) chk("R9 lamp lit last on clock", {7'b0, col_led_n}, 8'h00);
      if (k == 20) chk("R10 lamp off after on phase", {7'b0, col_led_n}, 8'h01);
      if (k == 27) chk("R10 collisions ignored in off phase", {7'b0, col_led_n}, 8'h01);
      if (k == 35) chk("R10 lamp idle and dark", {7'b0, col_led_n}, 8'h01);
    end
    coll_act = 1;
    @(negedge clk);
    coll_act = 0;
    chk("R10 idle lamp retriggers", {7'b0, col_led_n}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule